// File: doc/BRIEF.md
# Infrared Run-Length Receive Sampler

This block watches the output of a demodulating infrared receiver and turns it into a stream of run-length bytes. A tick generator divides the core clock by a fixed prescaler of 16 and then by a programmable divisor. On each tick the sensed level is added to the current run. When the level changes, or when a run reaches its longest codable length, the run is written as one byte into a small receive FIFO. Host logic empties that FIFO through a show-ahead read port.

Status lines show when data is waiting and when the FIFO has passed its interrupt threshold. A sticky overrun flag reports bytes that were lost, and a status-read strobe clears it. A one-cycle command sends the receiver back to its inactive state. In that state it ignores space and waits for the next pulse. A 16-bit counter next to the run coder counts rising edges of the raw carrier input while a pulse is being sensed, so software can estimate the carrier frequency of a burst.

Top module: `ir_rle_rx`

## Requirements
- R1: Each FIFO byte holds the run level in bit 7 (1 = space, 0 = pulse) and the run length in units, minus one, in bits 6:0. One byte therefore codes 1 to 128 units.
- R2: One unit lasts 16 × `cfg_div` clock cycles. A divisor of 0 acts as 1. A level held for K·16·`cfg_div` cycles is coded as K units.
- R3: A run longer than 128 units is written as a byte of length code 127 each time 128 units build up, and counting then continues with the same level flag. A run of exactly 128 units gives one byte.
- R4: When the sensed level changes, the current run is written at once, and the new run starts with that tick counted as its first unit.
- R5: After reset, and after `idle_cmd`, the receiver is inactive. It writes nothing while space is sensed and throws away any partial run. The first tick that senses a pulse starts a new run.
- R6: When `cfg_invert` is 1, a low `ir_in` is sensed as pulse. When it is 0, a high `ir_in` is sensed as pulse.
- R7: `data_avail` is 1 while the FIFO holds at least one byte. `irq` is 1 while it holds at least 8 bytes. `pop` removes the byte shown on `pop_data`.
- R8: A byte that arrives while the 16-entry FIFO is full is dropped, and the stored bytes are kept. The drop sets `overrun`, which stays set until a `stat_rd` cycle in which no new drop happens.
- R9: `car_count` counts rising edges of `ir_carrier` only while `car_en` is 1 and a pulse is sensed. It holds its value otherwise, `car_clr` forces it to zero, and it stops at all ones.
- R10: `car_valid` is 1 only when `car_count` is neither zero nor all ones.
- R11: After reset, `data_avail`, `irq` and `overrun` are 0 and `car_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| ir_in | input | 1 | Demodulated receiver level, asynchronous |
| ir_carrier | input | 1 | Raw carrier input, asynchronous |
| cfg_invert | input | 1 | Swap which input level is sensed as pulse |
| cfg_div | input | DIV_W | Tick divisor after the prescaler of 16 |
| idle_cmd | input | 1 | One-cycle command that makes the receiver inactive |
| pop | input | 1 | Remove the byte at the head of the FIFO |
| pop_data | output | 8 | Byte at the head of the FIFO (show-ahead) |
| stat_rd | input | 1 | Status-read strobe; clears `overrun` |
| data_avail | output | 1 | FIFO is not empty |
| overrun | output | 1 | Sticky flag: a byte was lost |
| irq | output | 1 | FIFO fill is at or above the threshold |
| car_en | input | 1 | Enables the carrier edge counter |
| car_clr | input | 1 | Clears the carrier edge counter |
| car_count | output | CAR_W | Carrier rising-edge count |
| car_valid | output | 1 | Count is neither zero nor all ones |

## Verification
Some rules are checked on every cycle. The interrupt never rises without data being present. An empty FIFO stays empty unless a byte is written. The overrun flag holds until it is read and clears when the read happens with no new drop. An idle command is never followed by a write. The carrier counter clears, saturates and holds as required. The exact byte values, the scaling by the divisor, the split of long runs, inversion, the discarding of partial runs and the preservation of stored data on overflow only show up in the bench's timed level sequences and FIFO readback.

// File: rtl/ir_rle_pkg.sv
package ir_rle_pkg;
  localparam int DUR_W   = 7;
  localparam int MAX_RUN = 2 ** DUR_W;

  typedef struct packed {
    logic             space;
    logic [DUR_W-1:0] dur_m1;
  } rle_code_t;
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int PRESCALE = 16,
  parameter int DIV_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0]    pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_last;
  logic             pre_wrap;
  logic             div_wrap;

  assign div_last = (div == '0) ? '0 : div - DIV_W'(1);
  assign pre_wrap = (pre_cnt == PW'(PRESCALE - 1));
  assign div_wrap = (div_cnt >= div_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= pre_wrap && div_wrap;
      if (pre_wrap) begin
        pre_cnt <= '0;
        div_cnt <= div_wrap ? '0 : div_cnt + DIV_W'(1);
      end else begin
        pre_cnt <= pre_cnt + PW'(1);
      end
    end
  end
endmodule

// File: rtl/ir_run_coder.sv
module ir_run_coder
  import ir_rle_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      lvl_pulse,
  input  logic      idle_cmd,
  output logic      push,
  output rle_code_t code
);
  localparam int CW = DUR_W + 1;

  logic          active;
  logic          run_pulse;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_m1;

  assign cnt_m1 = cnt - CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      run_pulse <= 1'b1;
      cnt       <= '0;
      push      <= 1'b0;
      code      <= '0;
    end else begin
      push <= 1'b0;
      if (idle_cmd) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (tick) begin
        if (!active) begin
          if (lvl_pulse) begin
            active    <= 1'b1;
            run_pulse <= 1'b1;
            cnt       <= CW'(1);
          end
        end else if (lvl_pulse == run_pulse) begin
          if (cnt == CW'(MAX_RUN - 1)) begin
            push        <= 1'b1;
            code.space  <= ~run_pulse;
            code.dur_m1 <= '1;
            cnt         <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end else begin
          if (cnt != '0) begin
            push        <= 1'b1;
            code.space  <= ~run_pulse;
            code.dur_m1 <= cnt_m1[DUR_W-1:0];
          end
          run_pulse <= lvl_pulse;
          cnt       <= CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ir_rle_fifo.sv
module ir_rle_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic                     rd_en,
  output logic [WIDTH-1:0]         rd_data,
  output logic [$clog2(DEPTH):0]   fill,
  output logic                     dropped
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic             full;
  logic             empty;
  logic             do_wr;
  logic             do_rd;

  assign full    = (fill == (AW+1)'(DEPTH));
  assign empty   = (fill == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign dropped = wr_en && full;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + AW'(1);
      if (do_rd) rd_ptr <= rd_ptr + AW'(1);
      case ({do_wr, do_rd})
        2'b10:   fill <= fill + (AW+1)'(1);
        2'b01:   fill <= fill - (AW+1)'(1);
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/ir_carrier_cnt.sv
module ir_carrier_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise,
  input  logic          gate,
  input  logic          en,
  input  logic          clr,
  output logic [CW-1:0] count,
  output logic          valid
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (en && gate && rise && (count != '1)) begin
      count <= count + CW'(1);
    end
  end

  assign valid = (count != '0) && (count != '1);
endmodule

// File: rtl/ir_rle_rx.sv
module ir_rle_rx
  import ir_rle_pkg::*;
#(
  parameter int PRESCALE  = 16,
  parameter int DIV_W     = 8,
  parameter int DEPTH     = 16,
  parameter int IRQ_LEVEL = 8,
  parameter int CAR_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ir_in,
  input  logic             ir_carrier,
  input  logic             cfg_invert,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             idle_cmd,
  input  logic             pop,
  output logic [7:0]       pop_data,
  input  logic             stat_rd,
  output logic             data_avail,
  output logic             overrun,
  output logic             irq,
  input  logic             car_en,
  input  logic             car_clr,
  output logic [CAR_W-1:0] car_count,
  output logic             car_valid
);
  localparam int FW = $clog2(DEPTH) + 1;

  logic [1:0]  in_sync;
  logic [2:0]  car_sync;
  logic        lvl_pulse;
  logic        tick;
  logic        code_push;
  rle_code_t   code;
  logic [FW-1:0] fill;
  logic        dropped;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_sync  <= '0;
      car_sync <= '0;
    end else begin
      in_sync  <= {in_sync[0], ir_in};
      car_sync <= {car_sync[1:0], ir_carrier};
    end
  end

  assign lvl_pulse = in_sync[1] ^ cfg_invert;

  ir_tick_gen #(.PRESCALE(PRESCALE), .DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .div(cfg_div), .tick(tick)
  );

  ir_run_coder u_coder (
    .clk(clk), .rst(rst), .tick(tick), .lvl_pulse(lvl_pulse),
    .idle_cmd(idle_cmd), .push(code_push), .code(code)
  );

  ir_rle_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(code_push), .wr_data(code),
    .rd_en(pop), .rd_data(pop_data), .fill(fill), .dropped(dropped)
  );

  always_ff @(posedge clk) begin
    if (rst)          overrun <= 1'b0;
    else if (dropped) overrun <= 1'b1;
    else if (stat_rd) overrun <= 1'b0;
  end

  assign data_avail = (fill != '0);
  assign irq        = (32'(fill) >= IRQ_LEVEL);

  ir_carrier_cnt #(.CW(CAR_W)) u_car (
    .clk(clk), .rst(rst), .rise(car_sync[1] && !car_sync[2]),
    .gate(lvl_pulse), .en(car_en), .clr(car_clr),
    .count(car_count), .valid(car_valid)
  );
endmodule

// File: rtl/ir_rle_rx_chk.sv
module ir_rle_rx_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          idle_cmd,
  input logic          stat_rd,
  input logic          car_en,
  input logic          car_clr,
  input logic          data_avail,
  input logic          overrun,
  input logic          irq,
  input logic [CW-1:0] car_count,
  input logic          push
);
  p_irq_needs_data_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> data_avail);

  p_empty_stays_r7: assert property (@(posedge clk) disable iff (rst)
    (!data_avail && !push) |=> !data_avail);

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (overrun && !stat_rd) |=> overrun);

  p_overrun_cleared_r8: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !push) |=> !overrun);

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    idle_cmd |=> !push);

  p_car_clear_r9: assert property (@(posedge clk) disable iff (rst)
    car_clr |=> (car_count == '0));

  p_car_saturate_r9: assert property (@(posedge clk) disable iff (rst)
    ((car_count == '1) && !car_clr) |=> (car_count == '1));

  p_car_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!car_en && !car_clr) |=> $stable(car_count));
endmodule

bind ir_rle_rx ir_rle_rx_chk #(.CW(CAR_W)) u_chk (
  .clk(clk), .rst(rst), .idle_cmd(idle_cmd), .stat_rd(stat_rd),
  .car_en(car_en), .car_clr(car_clr), .data_avail(data_avail),
  .overrun(overrun), .irq(irq), .car_count(car_count), .push(code_push)
);

// File: tb/test_ir_rle_rx.sv
`timescale 1ns/1ps
module test_ir_rle_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ir_in = 1'b0;
  logic        ir_carrier = 1'b0;
  logic        cfg_invert = 1'b0;
  logic [7:0]  cfg_div = 8'd1;
  logic        idle_cmd = 1'b0;
  logic        pop = 1'b0;
  logic [7:0]  pop_data;
  logic        stat_rd = 1'b0;
  logic        data_avail;
  logic        overrun;
  logic        irq;
  logic        car_en = 1'b0;
  logic        car_clr = 1'b0;
  logic [15:0] car_count;
  logic        car_valid;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  ir_rle_rx i_ir_rle_rx (
    .clk(clk), .rst(rst), .ir_in(ir_in), .ir_carrier(ir_carrier),
    .cfg_invert(cfg_invert), .cfg_div(cfg_div), .idle_cmd(idle_cmd),
    .pop(pop), .pop_data(pop_data), .stat_rd(stat_rd),
    .data_avail(data_avail), .overrun(overrun), .irq(irq),
    .car_en(car_en), .car_clr(car_clr), .car_count(car_count),
    .car_valid(car_valid)
  );

  // {invert, divisor, pulse units, space units, first byte, second byte}
  localparam logic [36:0] TAB [0:4] = '{
    {1'b0, 4'd1, 8'd5,   8'd3,   8'h04, 8'h82},
    {1'b1, 4'd1, 8'd1,   8'd1,   8'h00, 8'h80},
    {1'b0, 4'd3, 8'd4,   8'd2,   8'h03, 8'h81},
    {1'b0, 4'd2, 8'd128, 8'd7,   8'h7F, 8'h86},
    {1'b0, 4'd1, 8'd17,  8'd128, 8'h10, 8'hFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic hold(input logic pulse, input int units);
    ir_in = pulse ^ cfg_invert;
    step(units * 16 * ((cfg_div == 0) ? 1 : int'(cfg_div)));
  endtask

  task automatic idle;
    idle_cmd = 1'b1;
    step(1);
    idle_cmd = 1'b0;
  endtask

  task automatic pop_chk(input string req, input logic [7:0] exp);
    chk(req, {24'd0, pop_data}, {24'd0, exp});
    pop = 1'b1;
    step(1);
    pop = 1'b0;
  endtask

  task automatic prep(input logic inv, input logic [7:0] div);
    cfg_invert = inv;
    cfg_div    = div;
    ir_in      = inv;
    step(4 * 16 * int'(div) + 8);
    idle;
    while (data_avail) begin
      pop = 1'b1;
      step(1);
      pop = 1'b0;
    end
    stat_rd = 1'b1;
    step(1);
    stat_rd = 1'b0;
  endtask

  task automatic toggle(input int n);
    for (int i = 0; i < n; i++) begin
      ir_carrier = 1'b1;
      step(2);
      ir_carrier = 1'b0;
      step(2);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    step(4);
    rst = 1'b0;
    step(1);
    chk("R11 data_avail", {31'd0, data_avail}, 0);
    chk("R11 irq", {31'd0, irq}, 0);
    chk("R11 overrun", {31'd0, overrun}, 0);
    chk("R11 car_count", {16'd0, car_count}, 0);
    chk("R10 car_valid at zero", {31'd0, car_valid}, 0);

    // Table walk: R1 coding, R2 divisor, R3 128-unit runs, R4 flush, R6 invert
    for (int e = 0; e < 5; e++) begin
      prep(TAB[e][36], {4'd0, TAB[e][35:32]});
      hold(1'b1, int'(TAB[e][31:24]));
      hold(1'b0, int'(TAB[e][23:16]));
      hold(1'b1, 1);
      hold(1'b0, 3);
      idle;
      pop_chk("R1/R2/R3/R6 pulse byte", TAB[e][15:8]);
      pop_chk("R1/R3/R4 space byte", TAB[e][7:0]);
      pop_chk("R4 one-unit pulse byte", 8'h00);
      chk("R7 empty after table entry", {31'd0, data_avail}, 0);
    end

    // R3: run of 130 units splits into 127 code then 1 code
    prep(1'b0, 8'd1);
    hold(1'b1, 130);
    hold(1'b0, 2);
    idle;
    pop_chk("R3 full chunk", 8'h7F);
    pop_chk("R3 remainder", 8'h01);
    chk("R3 no extra byte", {31'd0, data_avail}, 0);

    // R5: inactive state ignores space and drops partial runs
    prep(1'b0, 8'd1);
    hold(1'b0, 20);
    chk("R5 space while inactive", {31'd0, data_avail}, 0);
    hold(1'b1, 2);
    hold(1'b0, 5);
    idle;
    hold(1'b0, 10);
    hold(1'b1, 1);
    hold(1'b0, 2);
    idle;
    pop_chk("R5 pulse before idle", 8'h01);
    pop_chk("R5 first pulse after idle", 8'h00);
    chk("R5 discarded space run", {31'd0, data_avail}, 0);

    // R7/R8: threshold and overflow
    prep(1'b0, 8'd1);
    for (int k = 1; k <= 20; k++) begin
      hold(k % 2 == 1, (k <= 16) ? 2 : 3);
      if (k == 8) chk("R7 irq below 8 bytes", {31'd0, irq}, 0);
      if (k == 8) chk("R7 data_avail with bytes", {31'd0, data_avail}, 1);
      if (k == 9) chk("R7 irq at 8 bytes", {31'd0, irq}, 1);
      if (k == 17) chk("R8 no overrun at exactly full", {31'd0, overrun}, 0);
      if (k == 18) chk("R8 overrun on drop", {31'd0, overrun}, 1);
    end
    idle;
    for (int b = 1; b <= 16; b++) begin
      if (b == 8) begin
        pop = 1'b1;
        step(1);
        pop = 1'b0;
      end else begin
        pop_chk("R8 stored byte kept", (b % 2 == 1) ? 8'h01 : 8'h81);
      end
    end
    chk("R8 dropped bytes absent", {31'd0, data_avail}, 0);
    chk("R8 overrun sticky", {31'd0, overrun}, 1);
    stat_rd = 1'b1;
    step(1);
    stat_rd = 1'b0;
    chk("R8 overrun cleared by status read", {31'd0, overrun}, 0);

    // R9/R10: carrier counter
    prep(1'b0, 8'd1);
    car_clr = 1'b1;
    step(1);
    car_clr = 1'b0;
    car_en = 1'b1;
    hold(1'b1, 1);
    toggle(10);
    step(8);
    chk("R9 count during pulse", {16'd0, car_count}, 10);
    chk("R10 valid mid-range", {31'd0, car_valid}, 1);
    ir_in = 1'b0;
    step(8);
    toggle(5);
    step(8);
    chk("R9 no count during space", {16'd0, car_count}, 10);
    ir_in = 1'b1;
    step(8);
    car_en = 1'b0;
    toggle(5);
    step(8);
    chk("R9 no count when disabled", {16'd0, car_count}, 10);
    car_clr = 1'b1;
    step(1);
    car_clr = 1'b0;
    step(1);
    chk("R9 clear", {16'd0, car_count}, 0);
    chk("R10 invalid at zero", {31'd0, car_valid}, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule